// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned N-bit operands (N defaults to 32) over N clock cycles and returns the full 2N-bit product. Its datapath has one N-bit adder and one 2N-bit working register. The multiplier operand is loaded into the lower half of that register, and the upper half is cleared. On each step, the register's bit 0 decides whether the captured multiplicand is added into the upper half. The whole register, with the adder's carry on top, then moves one place right. Product bits therefore fill the register from the top while multiplier bits leave at the bottom.

Control is a three-state machine. IDLE is the state after reset. RUN performs one add-and-shift step per cycle. DONE holds the result. The transitions are:
- GO: IDLE to RUN when start is high.
- STEP: RUN to RUN while the step count is below N-1.
- FINISH: RUN to DONE on the last step.
- RESTART: DONE to RUN when start is high.

A client raises start for one cycle with both operands valid. It then watches busy, and reads the product (whole, or as high and low halves) once done is high.

Top module: `seq_mult`

## Requirements
- R1: After reset, busy and done are 0 and the product is all zeros.
- R2: The operands are sampled only on a clock edge where start is high and the block is not busy. Busy is high from the next cycle on, and later changes on the operand inputs do not affect the result.
- R3: Busy stays high for exactly N cycles. Done rises in the cycle in which busy falls.
- R4: When done is high, the product equals the unsigned product of the captured operands. This holds at every corner, including all-ones times all-ones, where the carry out of the adder is kept.
- R5: The high-half output equals product bits 2N-1..N, and the low-half output equals bits N-1..0.
- R6: A start pulse while busy is ignored. The running multiply keeps its operands and its N-cycle length.
- R7: While done is high and start is low, done stays high and the product is unchanged.
- R8: A start pulse while done is high begins a new multiply (RESTART), with the same timing as from IDLE.
- R9: Busy and done are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiply (ignored while busy) |
| mcand | input | N | Multiplicand operand |
| mplier | input | N | Multiplier operand |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | Product valid and held |
| prod | output | 2N | Full product |
| prod_hi | output | N | Upper half of the product |
| prod_lo | output | N | Lower half of the product |

## Verification
The multiply is tried with zero operands, which show that no addition leaks in. It is tried with a factor of one, which shows the operand passing to the right half unchanged. All-ones times all-ones checks that the adder carry reaches the top bit. Sparse and random patterns check the bit-0 test across mixed add and shift-only steps. The expected value for each pattern comes from the language's own multiply operator. Separate scenarios cover:
- operand inputs scrambled after start, which tells true sampling apart from continuous use of the inputs;
- a start pulse in the middle of a run;
- back-to-back restarts from DONE.

// File: rtl/mult_pkg.sv
package mult_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mult_state_t;
endpackage

// File: rtl/mult_adder.sv
module mult_adder #(
    parameter int N = 32
) (
    input  logic [N-1:0] upper,
    input  logic [N-1:0] addend,
    input  logic         add_en,
    output logic [N:0]   sum
);
    logic [N-1:0] gated;

    always_comb begin
        gated = add_en ? addend : '0;
        sum   = {1'b0, upper} + {1'b0, gated};
    end
endmodule

// File: rtl/mult_datapath.sv
module mult_datapath #(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic [2*N-1:0] acc
);
    localparam int W = 2 * N;

    logic [N-1:0] mcand_q;
    logic [N:0]   sum;

    mult_adder #(.N(N)) u_add (
        .upper  (acc[W-1:N]),
        .addend (mcand_q),
        .add_en (acc[0]),
        .sum    (sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc     <= '0;
            mcand_q <= '0;
        end else if (load) begin
            acc     <= {{N{1'b0}}, mplier};
            mcand_q <= mcand;
        end else if (step) begin
            acc     <= {sum, acc[N-1:1]};
        end
    end
endmodule

// File: rtl/mult_ctrl.sv
module mult_ctrl
    import mult_pkg::*;
#(
    parameter int N = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    mult_state_t state, state_nx;
    logic [CW-1:0] step_cnt;
    logic          last_step;

    assign last_step = (step_cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step_cnt <= '0;
        end else begin
            state <= state_nx;
            if (load)
                step_cnt <= '0;
            else if (step)
                step_cnt <= step_cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)     state_nx = ST_RUN;
            ST_RUN:  if (last_step) state_nx = ST_DONE;
            ST_DONE: if (start)     state_nx = ST_RUN;
            default:                state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE: load = start;
            ST_RUN: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_DONE: begin
                load = start;
                done = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/seq_mult.sv
module seq_mult #(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] prod,
    output logic [N-1:0]   prod_hi,
    output logic [N-1:0]   prod_lo
);
    logic load;
    logic step;

    mult_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    mult_datapath #(.N(N)) u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .mcand  (mcand),
        .mplier (mplier),
        .acc    (prod)
    );

    assign prod_hi = prod[2*N-1:N];
    assign prod_lo = prod[N-1:0];
endmodule

// File: rtl/seq_mult_chk.sv
module seq_mult_chk #(
    parameter int N = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [N-1:0]   mcand,
    input logic [N-1:0]   mplier,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] prod
);
    int unsigned      busy_len;
    logic [2*N-1:0]   expect_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len <= 0;
            expect_q <= '0;
        end else begin
            busy_len <= busy ? busy_len + 1 : 0;
            if (start && !busy)
                expect_q <= {{N{1'b0}}, mcand} * {{N{1'b0}}, mplier};
        end
    end

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r3_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_len < N - 1) |=> busy);

    a_r3_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_len == N - 1) |=> (!busy && done));

    a_r4_product: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (prod == expect_q));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(prod)));
endmodule

bind seq_mult seq_mult_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .mcand  (mcand),
    .mplier (mplier),
    .busy   (busy),
    .done   (done),
    .prod   (prod)
);

// File: tb/seq_mult_tb.sv
`timescale 1ns/1ps
module seq_mult_tb;
    localparam int N = 32;
    localparam logic [N-1:0] ONES = '1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   mcand = '0;
    logic [N-1:0]   mplier = '0;
    logic           busy, done;
    logic [2*N-1:0] prod;
    logic [N-1:0]   prod_hi, prod_lo;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    seq_mult #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .prod(prod), .prod_hi(prod_hi), .prod_lo(prod_lo)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Counts busy cycles after the start edge; also watches R9.
    task automatic wait_done(output int cycles);
        cycles = 0;
        while (busy && cycles < N + 8) begin
            cycles++;
            if (done) check(1'b0, "R9 busy and done together", 1, 0);
            @(negedge clk);
        end
    endtask

    task automatic run_mul(input logic [N-1:0] a, input logic [N-1:0] b, input string name);
        int cyc;
        logic [2*N-1:0] exp;
        logic [2*N-1:0] held;
        exp = {{N{1'b0}}, a} * {{N{1'b0}}, b};
        @(negedge clk);
        start = 1'b1; mcand = a; mplier = b;
        @(negedge clk);
        start = 1'b0; mcand = ~a; mplier = ~b;
        check(busy == 1'b1, {"R2 busy after start ", name}, busy, 1);
        wait_done(cyc);
        check(cyc == N, {"R3 busy length ", name}, cyc, N);
        check(done == 1'b1, {"R3 done raised ", name}, done, 1);
        check(prod == exp, {"R4 product ", name}, prod, exp);
        check(prod_hi == exp[2*N-1:N] && prod_lo == exp[N-1:0],
              {"R5 halves ", name}, {prod_hi, prod_lo}, exp);
        held = prod;
        repeat (3) @(negedge clk);
        check(done && prod == held, {"R7 hold ", name}, prod, held);
    endtask

    task automatic test_reset();
        check(!busy && !done, "R1 flags after reset", {busy, done}, 0);
        check(prod == '0, "R1 product after reset", prod, 0);
    endtask

    task automatic test_start_while_busy();
        int cyc;
        logic [2*N-1:0] exp;
        exp = {{N{1'b0}}, 32'h0000_1234} * {{N{1'b0}}, 32'h0000_0F0F};
        @(negedge clk);
        start = 1'b1; mcand = 32'h0000_1234; mplier = 32'h0000_0F0F;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1; mcand = 32'hDEAD_BEEF; mplier = 32'hCAFE_F00D;
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
        check(cyc == N - 5, "R6 run length unchanged", cyc + 5, N);
        check(prod == exp, "R6 product of first operands", prod, exp);
    endtask

    task automatic test_restart();
        int cyc;
        @(negedge clk);
        check(done == 1'b1, "R8 done before restart", done, 1);
        start = 1'b1; mcand = 32'd7; mplier = 32'd9;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done, "R8 busy after restart", {busy, done}, 2);
        wait_done(cyc);
        check(cyc == N && prod == 64'd63, "R8 restart result", prod, 63);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_mul(32'd6, 32'd3, "six_three");
        run_mul(32'd0, 32'h89AB_CDEF, "zero_a");
        run_mul(32'h89AB_CDEF, 32'd0, "zero_b");
        run_mul(32'd1, 32'h8000_0001, "one_a");
        run_mul(32'hFEDC_BA98, 32'd1, "one_b");
        run_mul(ONES, ONES, "ones_ones");
        run_mul(ONES, 32'd1, "ones_one");
        run_mul(32'h8000_0000, 32'h8000_0000, "msb_msb");
        run_mul(32'hAAAA_AAAA, 32'h5555_5555, "alt");
        for (int i = 0; i < 6; i++) run_mul($urandom, $urandom, "random");
        test_start_while_busy();
        test_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule